// File: doc/BRIEF.md
# Sixteen-pin GPIO port with atomic bit set and clear

This block is a 16-pin general-purpose I/O port on a simple 32-bit register bus. Each pin has its own direction, output type (push-pull or open-drain) and pull selection. Software updates the output latch either with a plain word write or through two write-only registers. Those two registers set and clear single bits in one access, with no read-modify-write and no race between tasks that share the port.

On the pad side, the block receives the level each external agent applies and a flag per pin that says whether that agent drives at all. For every pin it resolves the level seen on the wire, whether the port drives it, and whether the port has cut off the external driver. The resolved levels are captured every cycle into a read-only input register. The reset values of the direction, pull and input registers are parameters, so each instance of the port can wake up with its own pin setup.

Top module: `gpio_port`

## Requirements
- R1: While reset is asserted, the direction word reads `MODE_RST`, the pull word reads `PULL_RST`, the input register reads `IDATA_RST`, and the output latch and output-type word read 0.
- R2: Pin n uses direction field bits [2n+1:2n] at offset 0x00. The code 2'b01 selects output; every other code behaves as input. The word reads back as written.
- R3: On an input pin with the external-driven flag high, the resolved level equals the external level. Writes to that pin's output latch leave its resolved level and its input-register bit unchanged.
- R4: On an input pin with no external driver, pull field bits [2n+1:2n] at offset 0x0C decide the level: 2'b01 gives 1, 2'b10 gives 0, and 2'b00 or 2'b11 gives 0.
- R5: An output pin whose output-type bit n at offset 0x04 is 0 (push-pull) resolves to its output-latch bit, whatever the external level. Its output-enable and disconnect flags are both 1.
- R6: An output pin whose output-type bit is 1 (open-drain) behaves as follows:
  - With latch bit 0, it resolves to 0 with output-enable and disconnect both 1.
  - With latch bit 1, output-enable and disconnect are 0, and the level follows the external level or the pull, as for an input pin.
- R7: The input register at offset 0x10 holds the resolved levels from the previous clock edge, and bus writes to it are ignored.
- R8: At offset 0x18, a write with bit n at 1 sets latch bit n, and a write with bit n+16 at 1 clears it. A write with both bits at 1 sets the bit. Bits written as 0 leave the latch unchanged. The register reads 0.
- R9: At offset 0x28, a 1 in bit n (n < 16) clears latch bit n, and bits 31:16 are ignored. The register reads 0.
- R10: The output latch at offset 0x14 and the output-type word read back their low 16 bits with the upper half at 0. Unmapped offsets read 0.
- R11: A register write takes effect at the clock edge that samples it, so the resolved pin outputs change right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| pad_in | input | 16 | Level applied by the external agent |
| pad_ext_drv | input | 16 | 1 when the external agent drives the pin |
| pad_level | output | 16 | Resolved pin level |
| pad_oe | output | 16 | 1 when the port drives the pin |
| pad_isolated | output | 16 | 1 when the external driver is cut off |

## Verification
Two functions can act in the same cycle: a single access to the set/clear register carries both the set and the clear request for one pin, and the set must win. A second collision comes from the latch changing while a pin is in input mode; that change must not leak into the input register. The bench walks every pin through a set-only, clear-only and combined access, and checks the latch against a model in which set overrides clear. It also toggles the latch with the direction at input and confirms that the resolved level and the input register keep the pad value.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int          NPIN      = 16,
  parameter int          AW        = 8,
  parameter logic [31:0] MODE_RST  = 32'h0000_0000,
  parameter logic [31:0] PULL_RST  = 32'h0000_0000,
  parameter logic [15:0] IDATA_RST = 16'h0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [7:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [15:0]   pad_in,
  input  logic [15:0]   pad_ext_drv,
  output logic [15:0]   pad_level,
  output logic [15:0]   pad_oe,
  output logic [15:0]   pad_isolated
);

  localparam int          FW       = 2 * NPIN;
  localparam logic [7:0]  A_MODE   = 8'h00;
  localparam logic [7:0]  A_OTYPE  = 8'h04;
  localparam logic [7:0]  A_PULL   = 8'h0C;
  localparam logic [7:0]  A_IDATA  = 8'h10;
  localparam logic [7:0]  A_ODATA  = 8'h14;
  localparam logic [7:0]  A_SETCLR = 8'h18;
  localparam logic [7:0]  A_CLR    = 8'h28;
  localparam logic [1:0]  M_OUT    = 2'b01;
  localparam logic [1:0]  P_UP     = 2'b01;

  logic [FW-1:0]   mode_q, pull_q;
  logic [NPIN-1:0] otype_q, odata_q, idata_q, odata_nxt;
  logic [NPIN-1:0] set_req, clr_req, is_out;

  wire wr = bus_sel && bus_we;

  assign set_req = (wr && bus_addr == A_SETCLR) ? bus_wdata[NPIN-1:0] : '0;
  assign clr_req = (wr && bus_addr == A_SETCLR) ? bus_wdata[2*NPIN-1:NPIN] :
                   (wr && bus_addr == A_CLR)    ? bus_wdata[NPIN-1:0] : '0;

  always_comb begin
    odata_nxt = (odata_q & ~clr_req) | set_req;
    if (wr && bus_addr == A_ODATA) odata_nxt = bus_wdata[NPIN-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_RST[FW-1:0];
      pull_q  <= PULL_RST[FW-1:0];
      otype_q <= '0;
      odata_q <= '0;
      idata_q <= IDATA_RST[NPIN-1:0];
    end else begin
      odata_q <= odata_nxt;
      idata_q <= pad_level;
      if (wr) begin
        case (bus_addr)
          A_MODE:  mode_q  <= bus_wdata[FW-1:0];
          A_PULL:  pull_q  <= bus_wdata[FW-1:0];
          A_OTYPE: otype_q <= bus_wdata[NPIN-1:0];
          default: ;
        endcase
      end
    end
  end

  for (genvar n = 0; n < NPIN; n++) begin : g_pin
    logic float_lvl, drive_lo;
    assign is_out[n]  = mode_q[2*n +: 2] == M_OUT;
    assign float_lvl  = pad_ext_drv[n] ? pad_in[n] : (pull_q[2*n +: 2] == P_UP);
    assign drive_lo   = otype_q[n] && !odata_q[n];
    assign pad_oe[n]  = is_out[n] && (!otype_q[n] || drive_lo);
    assign pad_isolated[n] = pad_oe[n];
    assign pad_level[n] = !pad_oe[n] ? float_lvl : (otype_q[n] ? 1'b0 : odata_q[n]);
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_MODE:  bus_rdata[FW-1:0]   = mode_q;
      A_PULL:  bus_rdata[FW-1:0]   = pull_q;
      A_OTYPE: bus_rdata[NPIN-1:0] = otype_q;
      A_ODATA: bus_rdata[NPIN-1:0] = odata_q;
      A_IDATA: bus_rdata[NPIN-1:0] = idata_q;
      default: bus_rdata = '0;
    endcase
  end

  // R8
  odata_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_SETCLR) |=>
      ((odata_q & $past(bus_wdata[NPIN-1:0])) == $past(bus_wdata[NPIN-1:0])));

  // R8
  odata_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_SETCLR) |=>
      ((odata_q & $past(bus_wdata[2*NPIN-1:NPIN]) & ~$past(bus_wdata[NPIN-1:0])) == '0));

  // R9
  odata_rstonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_CLR) |=> ((odata_q & $past(bus_wdata[NPIN-1:0])) == '0));

  // R11
  odata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && (bus_addr == A_ODATA || bus_addr == A_SETCLR || bus_addr == A_CLR))
      |=> $stable(odata_q));

  // R5
  pushpull_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((is_out & ~otype_q & (pad_level ^ odata_q)) == '0));

  // R8
  wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && (bus_addr == A_SETCLR || bus_addr == A_CLR)) |-> bus_rdata == '0);

endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_we = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [15:0] pad_in = 0, pad_ext_drv = 0, pad_level, pad_oe, pad_isolated;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_port #(.MODE_RST(32'h0000_0005), .PULL_RST(32'h0000_0040), .IDATA_RST(16'h1234)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_ext_drv(pad_ext_drv),
    .pad_level(pad_level), .pad_oe(pad_oe), .pad_isolated(pad_isolated));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  function automatic logic [47:0] model(logic [31:0] m, logic [15:0] ot, logic [31:0] pu,
                                        logic [15:0] od, logic [15:0] drv, logic [15:0] pin);
    logic [15:0] lv, oe;
    for (int n = 0; n < 16; n++) begin
      logic fl;
      fl = drv[n] ? pin[n] : (pu[2*n +: 2] == 2'b01);
      oe[n] = (m[2*n +: 2] == 2'b01) && (!ot[n] || !od[n]);
      lv[n] = oe[n] ? (ot[n] ? 1'b0 : od[n]) : fl;
    end
    return {lv, oe, oe};
  endfunction

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r, m, pu;
    logic [15:0] ot, od, exp_od;
    logic [47:0] e;
    // R1 reset state
    #3;
    rd(8'h00, r); chk("R1 mode", r, 32'h5);
    rd(8'h0C, r); chk("R1 pull", r, 32'h40);
    rd(8'h10, r); chk("R1 idata", r, 32'h1234);
    rd(8'h14, r); chk("R1 odata", r, 0);
    rd(8'h04, r); chk("R1 otype", r, 0);
    @(negedge clk); rst_n = 1;

    // R10 readback and unmapped
    wr(8'h04, 32'hFFFF_A5A5); rd(8'h04, r); chk("R10 otype", r, 32'hA5A5);
    wr(8'h14, 32'hFFFF_1234); rd(8'h14, r); chk("R10 odata", r, 32'h1234);
    rd(8'h08, r); chk("R10 unmapped", r, 0);
    rd(8'h18, r); chk("R8 reads zero", r, 0);
    rd(8'h28, r); chk("R9 reads zero", r, 0);
    wr(8'h04, 0);

    // R7 idata write ignored
    wr(8'h00, 0); wr(8'h0C, 0); pad_ext_drv = 16'hFFFF; pad_in = 16'h0F0F;
    wr(8'h10, 32'hFFFF); @(posedge clk);
    rd(8'h10, r); chk("R7 idata ro", r, 32'h0F0F);

    // R8 / R9 per-pin set, clear, collision
    wr(8'h14, 0); exp_od = 0;
    for (int p = 0; p < 16; p++) begin
      wr(8'h18, 32'h1 << p); exp_od |= 16'h1 << p;
      rd(8'h14, r); chk("R8 set", r, {16'h0, exp_od});
      wr(8'h18, 32'h1 << (p + 16)); exp_od &= ~(16'h1 << p);
      rd(8'h14, r); chk("R8 clear", r, {16'h0, exp_od});
      wr(8'h18, (32'h1 << p) | (32'h1 << (p + 16))); exp_od |= 16'h1 << p;
      rd(8'h14, r); chk("R8 set wins", r, {16'h0, exp_od});
      wr(8'h28, 32'hFFFF_0000 | (32'h1 << p)); exp_od &= ~(16'h1 << p);
      rd(8'h14, r); chk("R9 clear-only", r, {16'h0, exp_od});
      if (p % 3 == 0) begin
        wr(8'h18, 32'h1 << p); exp_od |= 16'h1 << p;
      end
    end
    for (int i = 0; i < 40; i++) begin
      r = $urandom;
      if (i % 2 == 0) begin
        wr(8'h18, r); exp_od = (exp_od & ~r[31:16]) | r[15:0];
      end else begin
        wr(8'h28, r); exp_od = exp_od & ~r[15:0];
      end
      rd(8'h14, r); chk("R8 R9 mixed", r, {16'h0, exp_od});
    end

    // R3 input pins ignore latch changes
    wr(8'h00, 32'hAAAA_AAAA); pad_ext_drv = 16'hFFFF; pad_in = 16'hC3C3;
    for (int i = 0; i < 4; i++) begin
      wr(8'h18, (i % 2) ? 32'hFFFF_0000 : 32'h0000_FFFF);
      #1 chk("R3 level", {16'h0, pad_level}, 32'hC3C3);
      @(posedge clk);
      rd(8'h10, r); chk("R3 idata", r, 32'hC3C3);
    end

    // R2 R4 R5 R6 R11 random configuration sweep
    for (int i = 0; i < 400; i++) begin
      m = $urandom; ot = 16'($urandom); pu = $urandom; od = 16'($urandom);
      pad_ext_drv = 16'($urandom); pad_in = 16'($urandom);
      if (i < 4) begin m = {16{2'(i)}}; end
      if (i >= 4 && i < 8) begin pu = {16{2'(i)}}; pad_ext_drv = 0; end
      wr(8'h00, m); wr(8'h04, ot); wr(8'h0C, pu); wr(8'h14, od);
      e = model(m, ot, pu, od, pad_ext_drv, pad_in);
      #1;
      chk("R5 R6 R4 R11 level", {16'h0, pad_level}, {16'h0, e[47:32]});
      chk("R5 R6 oe", {16'h0, pad_oe}, {16'h0, e[31:16]});
      chk("R5 R6 isolated", {16'h0, pad_isolated}, {16'h0, e[15:0]});
      @(posedge clk);
      rd(8'h10, r); chk("R7 idata", r, {16'h0, e[47:32]});
      if (i % 50 == 0) begin rd(8'h00, r); chk("R2 mode readback", r, m); end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule